// File: doc/BRIEF.md
# Dual-Clock FIFO with In-Band Programmable Thresholds

This block is a first-in first-out buffer of 512 words, 18 bits each, placed between two unrelated clock domains. A producer pushes a word on a rising edge of the write clock while its write strobe is high. A consumer pops the head word on a rising edge of the read clock while its read strobe is high. The head word is always visible on the data outputs while the buffer holds data, so a consumer can inspect it before popping. The output enable is active low, and when it is high the data outputs float.

Four status outputs describe the fill level. Two are active low: one for full, one for empty. The other two are active high: a half-full flag and a single flag for "nearly empty or nearly full". The two thresholds behind that combined flag come from the data inputs. After reset, while the program strobe is held low, the first accepted write edge supplies the lower offset and the second supplies the upper offset. Those words are consumed as settings and are not queued. The read and write pointers cross between the domains in Gray code through two-stage synchronisers. The full-side flags are computed in the write domain and the empty flag in the read domain.

Top module: `dcfifo_pf`

## Requirements
- R1: Accepted words come out in the order they were accepted, 18 bits unchanged. At most 512 words are held at once. A word is accepted on a write-clock rising edge with `wr_en` high and `full_n` high. A word is removed on a read-clock rising edge with `rd_en` high and `empty_n` high.
- R2: `full_n` is low exactly when the write side counts 512 stored words. Write strobes while `full_n` is low leave the stored contents and the order unchanged.
- R3: `empty_n` is low when the read side sees no stored word. Read strobes while `empty_n` is low do not advance the head.
- R4: `half_full` is high when the write side counts 256 or more stored words, and low otherwise.
- R5: After reset with `prog_n` low, the first accepted write edge loads the lower offset L from `din[7:0]` and the second loads the upper offset U from `din[7:0]`. Neither word is stored.
- R6: `almost_flag` is high when the write-side count c satisfies c <= L or c >= 512 - U, and low for L+1 <= c <= 511-U.
- R7: If `prog_n` is high at the first accepted write edge after reset, L = U = 64 and that word is stored.
- R8: If exactly one programming edge occurs and `prog_n` is high at the next accepted write edge, U takes the value of L and that next word is stored.
- R9: While `rst_n` is low, and right after it is released, `full_n` = 1, `empty_n` = 0, `half_full` = 0, `almost_flag` = 1, and both pointers are at zero.
- R10: The first word written into an empty buffer appears on `dout` and drives `empty_n` high with no read strobe. This takes at most three read-clock edges after the write edge.
- R11: While `oe_n` is high, `dout` is high-impedance and does not present the head word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock |
| wr_en | input | 1 | Write strobe, sampled on rising `wr_clk` |
| din | input | 18 | Write data; bits 7:0 carry offsets during programming |
| prog_n | input | 1 | Active-low threshold programming select |
| rd_clk | input | 1 | Read-domain clock |
| rd_en | input | 1 | Read strobe, sampled on rising `rd_clk` |
| oe_n | input | 1 | Active-low output enable |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| dout | output | 18 | Head word, or high-impedance |
| full_n | output | 1 | Low when full (write domain) |
| empty_n | output | 1 | Low when empty (read domain) |
| half_full | output | 1 | High at 256 or more words (write domain) |
| almost_flag | output | 1 | Combined near-empty / near-full flag (write domain) |

## Verification
A read pointer that drifts or skips shows at once as a wrong head word on `dout` at the next pop. A write pointer that moves on a blocked or programming edge shows as an extra or misplaced word, at the latest when the buffer is drained. A wrong synchroniser or Gray conversion makes the settled flags disagree with the true fill level a few clocks after activity stops. It can also let `empty_n` rise while the bench's queue is empty. Offsets that were latched wrongly move the `almost_flag` boundaries, and this is visible as soon as the fill level crosses L+1 or 512-U.

// File: rtl/fifo_pf_pkg.sv
`timescale 1ns/1ps
package fifo_pf_pkg;
  localparam int GW = 16;

  typedef enum logic [1:0] {PS_LOW, PS_HIGH, PS_RUN} pstate_t;

  function automatic logic [GW-1:0] bin2gray(input logic [GW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [GW-1:0] gray2bin(input logic [GW-1:0] g);
    logic [GW-1:0] b;
    b[GW-1] = g[GW-1];
    for (int i = GW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  function automatic logic half_hit(input int unsigned cnt, input int unsigned depth);
    return cnt >= depth / 2;
  endfunction

  function automatic logic almost_hit(input int unsigned cnt, input int unsigned lo,
                                      input int unsigned hi, input int unsigned depth);
    return (cnt <= lo) || (cnt + hi >= depth);
  endfunction
endpackage

// File: rtl/gray_sync.sv
`timescale 1ns/1ps
module gray_sync #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  import fifo_pf_pkg::*;
  logic [PW-1:0] stage1, stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  assign bin_out = PW'(gray2bin(GW'(stage2)));
endmodule

// File: rtl/store_ram.sv
`timescale 1ns/1ps
module store_ram #(
  parameter int AW = 9,
  parameter int DW = 18
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/wr_ctrl.sv
`timescale 1ns/1ps
module wr_ctrl #(
  parameter int AW   = 9,
  parameter int DW   = 18,
  parameter int OW   = 8,
  parameter int ODEF = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  input  logic          prog_n,
  input  logic [AW:0]   rd_bin_s,
  output logic          mem_we,
  output logic [AW:0]   wr_bin,
  output logic [AW:0]   wr_gray,
  output logic [AW:0]   wcount,
  output logic          prog_take,
  output logic          full_n,
  output logic          half_full,
  output logic          almost_flag
);
  import fifo_pf_pkg::*;
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  pstate_t       ps;
  logic [OW-1:0] ofs_lo, ofs_hi;
  logic          accept;
  logic [PW-1:0] wr_nxt;

  assign wcount    = wr_bin - rd_bin_s;
  assign accept    = wr_en && (wcount != PW'(DEPTH));
  assign prog_take = accept && (ps != PS_RUN) && !prog_n;
  assign mem_we    = accept && !prog_take;
  assign wr_nxt    = wr_bin + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps      <= PS_LOW;
      ofs_lo  <= OW'(ODEF);
      ofs_hi  <= OW'(ODEF);
      wr_bin  <= '0;
      wr_gray <= '0;
    end else begin
      if (accept) begin
        case (ps)
          PS_LOW: begin
            if (!prog_n) begin
              ofs_lo <= din[OW-1:0];
              ps     <= PS_HIGH;
            end else begin
              ps <= PS_RUN;
            end
          end
          PS_HIGH: begin
            ofs_hi <= prog_n ? ofs_lo : din[OW-1:0];
            ps     <= PS_RUN;
          end
          default: ps <= PS_RUN;
        endcase
      end
      if (mem_we) begin
        wr_bin  <= wr_nxt;
        wr_gray <= PW'(bin2gray(GW'(wr_nxt)));
      end
    end
  end

  assign full_n      = (wcount != PW'(DEPTH));
  assign half_full   = half_hit(32'(wcount), 32'(DEPTH));
  assign almost_flag = almost_hit(32'(wcount), 32'(ofs_lo), 32'(ofs_hi), 32'(DEPTH));
endmodule

// File: rtl/rd_ctrl.sv
`timescale 1ns/1ps
module rd_ctrl #(
  parameter int AW = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic [AW:0] wr_bin_s,
  output logic [AW:0] rd_bin,
  output logic [AW:0] rd_gray,
  output logic        rd_take,
  output logic        empty_n
);
  import fifo_pf_pkg::*;
  localparam int PW = AW + 1;
  logic [PW-1:0] rd_nxt;

  assign empty_n = (rd_bin != wr_bin_s);
  assign rd_take = rd_en && empty_n;
  assign rd_nxt  = rd_bin + PW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_bin  <= '0;
      rd_gray <= '0;
    end else if (rd_take) begin
      rd_bin  <= rd_nxt;
      rd_gray <= PW'(bin2gray(GW'(rd_nxt)));
    end
  end
endmodule

// File: rtl/dcfifo_pf.sv
`timescale 1ns/1ps
module dcfifo_pf #(
  parameter int AW   = 9,
  parameter int DW   = 18,
  parameter int OW   = 8,
  parameter int ODEF = 64
) (
  input  logic          wr_clk,
  input  logic          wr_en,
  input  logic [DW-1:0] din,
  input  logic          prog_n,
  input  logic          rd_clk,
  input  logic          rd_en,
  input  logic          oe_n,
  input  logic          rst_n,
  output logic [DW-1:0] dout,
  output logic          full_n,
  output logic          empty_n,
  output logic          half_full,
  output logic          almost_flag
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wr_bin, wr_gray, wcount, rd_bin, rd_gray;
  logic [PW-1:0] rd_bin_s, wr_bin_s;
  logic          mem_we, prog_take, rd_take;
  logic [DW-1:0] head;

  wr_ctrl #(.AW(AW), .DW(DW), .OW(OW), .ODEF(ODEF)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .wr_en(wr_en), .din(din), .prog_n(prog_n),
    .rd_bin_s(rd_bin_s), .mem_we(mem_we), .wr_bin(wr_bin), .wr_gray(wr_gray),
    .wcount(wcount), .prog_take(prog_take), .full_n(full_n),
    .half_full(half_full), .almost_flag(almost_flag)
  );

  rd_ctrl #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .rd_en(rd_en), .wr_bin_s(wr_bin_s),
    .rd_bin(rd_bin), .rd_gray(rd_gray), .rd_take(rd_take), .empty_n(empty_n)
  );

  gray_sync #(.PW(PW)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .gray_in(wr_gray), .bin_out(wr_bin_s)
  );

  gray_sync #(.PW(PW)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .gray_in(rd_gray), .bin_out(rd_bin_s)
  );

  store_ram #(.AW(AW), .DW(DW)) u_ram (
    .wclk(wr_clk), .we(mem_we), .waddr(wr_bin[AW-1:0]), .wdata(din),
    .raddr(rd_bin[AW-1:0]), .rdata(head)
  );

  assign dout = oe_n ? {DW{1'bz}} : head;
endmodule

// File: rtl/dcfifo_pf_checker.sv
`timescale 1ns/1ps
module fifo_pf_checker #(
  parameter int AW = 9
) (
  input logic        wr_clk,
  input logic        rd_clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        full_n,
  input logic        empty_n,
  input logic        half_full,
  input logic        almost_flag,
  input logic        prog_take,
  input logic        rd_take,
  input logic [AW:0] wr_bin,
  input logic [AW:0] wr_gray,
  input logic [AW:0] rd_bin,
  input logic [AW:0] wcount
);
  localparam int DEPTH = 1 << AW;

  assert_no_overflow_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
    32'(wcount) <= DEPTH)
    else $error("wcount above depth");

  assert_gray_step_R1: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wr_gray ^ $past(wr_gray)) <= 1)
    else $error("write gray pointer moved more than one bit");

  assert_full_blocks_R2: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!full_n && wr_en) |=> $stable(wr_bin))
    else $error("write pointer moved while full");

  assert_empty_blocks_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!empty_n && rd_en) |=> $stable(rd_bin))
    else $error("read pointer moved while empty");

  assert_empty_no_take_R3: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !rd_take)
    else $error("read accepted while empty");

  assert_prog_unstored_R5: assert property (@(posedge wr_clk) disable iff (!rst_n)
    prog_take |=> $stable(wr_bin))
    else $error("programming word was stored");

  assert_full_implies_flags_R6: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> (half_full && almost_flag))
    else $error("full without half/almost flags");
endmodule

bind dcfifo_pf fifo_pf_checker #(.AW(AW)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
  .full_n(full_n), .empty_n(empty_n), .half_full(half_full),
  .almost_flag(almost_flag), .prog_take(prog_take), .rd_take(rd_take),
  .wr_bin(wr_bin), .wr_gray(wr_gray), .rd_bin(rd_bin), .wcount(wcount)
);

// File: tb/sim_dcfifo_pf.sv
`timescale 1ns/1ps
module sim_dcfifo_pf;
  logic        wr_clk = 0, rd_clk = 0;
  logic        wr_en = 0, rd_en = 0, prog_n = 1, oe_n = 0, rst_n = 0;
  logic [17:0] din = '0;
  wire  [17:0] dout;
  wire         full_n, empty_n, half_full, almost_flag;

  int checks = 0, fails = 0;
  int lo_ofs = 64, hi_ofs = 64;
  logic [17:0] seq = 18'd1;
  logic [17:0] q[$];
  bit mon_on = 0;

  always #4   wr_clk = ~wr_clk;
  always #5.5 rd_clk = ~rd_clk;

  dcfifo_pf u0 (
    .wr_clk(wr_clk), .wr_en(wr_en), .din(din), .prog_n(prog_n),
    .rd_clk(rd_clk), .rd_en(rd_en), .oe_n(oe_n), .rst_n(rst_n),
    .dout(dout), .full_n(full_n), .empty_n(empty_n),
    .half_full(half_full), .almost_flag(almost_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (level=%0d) t=%0t", tag, act, exp, q.size(), $time);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rd_clk);
    repeat (8) @(negedge wr_clk);
  endtask

  task automatic check_flags(input string where);
    int n = q.size();
    settle();
    chk({where, " R2 full_n"},      32'(full_n),      32'(n != 512));
    chk({where, " R3 empty_n"},     32'(empty_n),     32'(n != 0));
    chk({where, " R4 half_full"},   32'(half_full),   32'(n >= 256));
    chk({where, " R6 almost_flag"}, 32'(almost_flag), 32'((n <= lo_ofs) || (n >= 512 - hi_ofs)));
  endtask

  task automatic do_reset();
    @(negedge wr_clk);
    rst_n = 0; wr_en = 0; rd_en = 0;
    repeat (3) @(negedge rd_clk);
    q.delete();
    lo_ofs = 64; hi_ofs = 64;
    chk("R9 full_n in reset",      32'(full_n),      1);
    chk("R9 empty_n in reset",     32'(empty_n),     0);
    chk("R9 half_full in reset",   32'(half_full),   0);
    chk("R9 almost_flag in reset", 32'(almost_flag), 1);
    @(negedge wr_clk);
    rst_n = 1;
    repeat (2) @(negedge rd_clk);
  endtask

  task automatic put_word(input logic [17:0] d, input bit store);
    @(negedge wr_clk);
    while (!full_n) @(negedge wr_clk);
    wr_en = 1; din = d;
    if (store) q.push_back(d);
    @(posedge wr_clk); #1;
    wr_en = 0;
  endtask

  task automatic write_word();
    put_word(seq, 1);
    seq = seq + 18'd1;
  endtask

  task automatic fill_to(input int n);
    while (q.size() < n) write_word();
  endtask

  task automatic read_word();
    @(negedge rd_clk);
    while (!empty_n) @(negedge rd_clk);
    if (q.size() == 0) begin
      chk("R3 empty_n high with nothing queued", 32'(empty_n), 0);
    end else begin
      chk("R1 head word order", 32'(dout), 32'(q[0]));
      void'(q.pop_front());
    end
    rd_en = 1;
    @(posedge rd_clk); #1;
    rd_en = 0;
  endtask

  always begin
    @(posedge rd_clk); #2;
    if (mon_on && rst_n && empty_n)
      chk("R3 empty_n implies stored word", 32'(q.size() > 0), 1);
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired R1 actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge wr_clk);
    do_reset();
    chk("R9 full_n after release",      32'(full_n),      1);
    chk("R9 empty_n after release",     32'(empty_n),     0);
    chk("R9 almost_flag after release", 32'(almost_flag), 1);
    mon_on = 1;

    // R5: program L=5, U=10 in-band; words not stored
    prog_n = 0;
    put_word(18'h3FF05, 0); lo_ofs = 5;
    put_word(18'h3FF0A, 0); hi_ofs = 10;
    prog_n = 1;
    check_flags("R5 after programming");
    fill_to(5);   check_flags("R6 c=L");
    fill_to(6);   check_flags("R6 c=L+1");
    fill_to(255); check_flags("R4 c=255");
    fill_to(256); check_flags("R4 c=256");
    fill_to(501); check_flags("R6 c=511-U");
    fill_to(502); check_flags("R6 c=512-U");
    fill_to(512); check_flags("R2 full");

    // R2: writes while full are ignored
    @(negedge wr_clk);
    wr_en = 1; din = 18'h3FFFF;
    repeat (3) @(negedge wr_clk);
    wr_en = 0;
    check_flags("R2 after blocked writes");
    repeat (512) read_word();
    check_flags("R2 R3 drained");

    // R3: reads while empty are ignored; R10 fall-through
    @(negedge rd_clk);
    rd_en = 1;
    repeat (3) @(negedge rd_clk);
    rd_en = 0;
    put_word(18'h2A5A5, 1);
    repeat (3) @(negedge rd_clk);
    chk("R10 empty_n raised without read", 32'(empty_n), 1);
    chk("R10 first word on dout",          32'(dout),    32'h2A5A5);
    put_word(18'h15A5A, 1);
    settle();
    chk("R10 head unchanged by second write", 32'(dout), 32'h2A5A5);

    // R11: output enable
    oe_n = 1; #1;
    chk("R11 dout not driving head", 32'(dout === 18'h2A5A5), 0);
    oe_n = 0; #1;
    chk("R11 dout restored", 32'(dout), 32'h2A5A5);
    read_word();
    read_word();
    check_flags("R3 empty again");

    // R7: defaults when prog_n high at first edge
    do_reset();
    prog_n = 1;
    write_word();
    check_flags("R7 first word stored");
    fill_to(64);  check_flags("R7 c=64");
    fill_to(65);  check_flags("R7 c=65");
    fill_to(447); check_flags("R7 c=447");
    fill_to(448); check_flags("R7 c=448");

    // R8: single programming edge, U copies L
    do_reset();
    prog_n = 0;
    put_word(18'h00014, 0); lo_ofs = 20;
    prog_n = 1;
    write_word(); hi_ofs = 20;
    check_flags("R8 word after single prog stored");
    fill_to(20);  check_flags("R8 c=20");
    fill_to(21);  check_flags("R8 c=21");
    fill_to(491); check_flags("R8 c=491");
    fill_to(492); check_flags("R8 c=492");

    // R1: concurrent traffic with unrelated clocks
    do_reset();
    prog_n = 0;
    put_word(18'h0001E, 0); lo_ofs = 30;
    put_word(18'h00028, 0); hi_ofs = 40;
    prog_n = 1;
    fork
      begin
        for (int i = 0; i < 600; i++) begin
          if ($urandom % 3 == 0) @(negedge wr_clk);
          write_word();
        end
      end
      begin
        for (int i = 0; i < 560; i++) begin
          if ($urandom % 2 == 0) @(negedge rd_clk);
          read_word();
        end
      end
    join
    check_flags("R1 after concurrent traffic");
    while (q.size() > 0) read_word();
    check_flags("R1 drained");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule